// File: doc/BRIEF.md
# Carry-Pipelined Split Accumulator

This block keeps a running sum of input words, wrapping modulo 2^W. To shorten the critical path, the adder is cut into two sections. The lower section adds the low operand bits. It places its carry-out in a flip-flop. The upper section adds that stored carry one clock later, together with its own operand bits and controls, which are held back by one register. The lower section's sum also passes through one extra register, so the two halves form one coherent word at the output.

Each cycle the user may assert an enable, which adds the operand word, and a synchronous clear, which restarts the sum. An aligned result and a valid flag appear two clocks after the input that produced them.

Top module: `carry_split_acc`

## Requirements
- R1: `out_sum` two clock edges after an enabled, non-clearing input equals the previous sum plus `in_data`, modulo 2^W.
- R2: `out_valid` equals `in_en` as it was two clock edges earlier.
- R3: an input with `in_en` = 0 and `in_clr` = 0 leaves the sum unchanged, whatever `in_data` holds.
- R4: `in_clr` = 1 with `in_en` = 0 makes `out_sum` zero two edges later.
- R5: `in_clr` = 1 with `in_en` = 1 makes `out_sum` equal that cycle's `in_data` two edges later.
- R6: a carry produced by the lower `LO_W` bits reaches the upper section, so additions that cross the split point are exact.
- R7: a carry out of bit W-1 is dropped, and the sum wraps modulo 2^W.
- R8: while `rst` is high and on the first cycle after it, `out_sum` and `out_valid` are zero.
- R9: a carry produced by the addition just before a clear does not appear in the sum after that clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Add `in_data` this cycle |
| in_clr | input | 1 | Restart the sum this cycle |
| in_data | input | W | Operand word |
| out_sum | output | W | Aligned accumulated sum |
| out_valid | output | 1 | `in_en` delayed two cycles |

## Verification
The bench builds one instance with W = 8 and LO_W = 3. At that size it can sweep every operand value many times, so carries across the split, clears and wraps occur in all positions. A second instance keeps the default 41-bit width with a 21-bit lower section. Directed words drive that instance across its real split boundary and past its top bit, and both instances are compared against an arithmetic model every cycle.

// File: rtl/csacc_pkg.sv
`timescale 1ns/1ps
package csacc_pkg;

    localparam int DEF_W    = 41;
    localparam int DEF_LO_W = 21;

    typedef struct packed {
        logic add;
        logic restart;
    } acc_ctl_t;

    function automatic acc_ctl_t make_ctl(input logic add, input logic restart);
        acc_ctl_t c;
        c.add     = add;
        c.restart = restart;
        return c;
    endfunction

endpackage

// File: rtl/csacc_delay.sv
`timescale 1ns/1ps
module csacc_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [DEPTH+1];

    assign stage[0] = d;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[k+1] <= '0;
            else     stage[k+1] <= stage[k];
        end
    end

    assign q = stage[DEPTH];
endmodule

// File: rtl/csacc_lo.sv
`timescale 1ns/1ps
module csacc_lo
    import csacc_pkg::*;
#(
    parameter int LW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_ctl_t      ctl,
    input  logic [LW-1:0] opnd,
    output logic [LW-1:0] part_sum,
    output logic          carry_q
);
    logic [LW:0] wide_add;

    assign wide_add = {1'b0, part_sum} + {1'b0, opnd};

    always_ff @(posedge clk) begin
        if (rst) begin
            part_sum <= '0;
            carry_q  <= 1'b0;
        end else if (ctl.restart) begin
            part_sum <= ctl.add ? opnd : '0;
            carry_q  <= 1'b0;
        end else if (ctl.add) begin
            part_sum <= wide_add[LW-1:0];
            carry_q  <= wide_add[LW];
        end else begin
            carry_q  <= 1'b0;
        end
    end

    // R9: a carry only follows an addition that did not restart the sum
    a_r9_carry_only_after_add: assert property (@(posedge clk) disable iff (rst)
        carry_q |-> $past(ctl.add && !ctl.restart));
endmodule

// File: rtl/csacc_hi.sv
`timescale 1ns/1ps
module csacc_hi
    import csacc_pkg::*;
#(
    parameter int HW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_ctl_t      ctl_d,
    input  logic [HW-1:0] opnd_d,
    input  logic          carry_in,
    output logic [HW-1:0] part_sum
);
    logic [HW-1:0] cin_ext;
    logic [HW-1:0] base;

    assign cin_ext = {{(HW-1){1'b0}}, carry_in};
    assign base    = ctl_d.restart ? '0 : part_sum;

    always_ff @(posedge clk) begin
        if (rst)
            part_sum <= '0;
        else if (ctl_d.add || ctl_d.restart)
            part_sum <= base + (ctl_d.add ? opnd_d : '0) + cin_ext;
    end

    // R3: with no add and no restart, the upper section keeps its value
    a_r3_hi_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl_d.add && !ctl_d.restart) |=> $stable(part_sum));
endmodule

// File: rtl/carry_split_acc.sv
`timescale 1ns/1ps
module carry_split_acc
    import csacc_pkg::*;
#(
    parameter int W    = DEF_W,
    parameter int LO_W = DEF_LO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_en,
    input  logic         in_clr,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] out_sum,
    output logic         out_valid
);
    localparam int HI_W   = W - LO_W;
    localparam int SKEW_W = HI_W + $bits(acc_ctl_t);

    acc_ctl_t          ctl_now, ctl_late;
    logic [HI_W-1:0]   hi_opnd_late;
    logic [LO_W-1:0]   lo_sum, lo_sum_late;
    logic [HI_W-1:0]   hi_sum;
    logic              carry_q;

    assign ctl_now = make_ctl(in_en, in_clr);

    csacc_lo #(.LW(LO_W)) u_lo (
        .clk(clk), .rst(rst), .ctl(ctl_now), .opnd(in_data[LO_W-1:0]),
        .part_sum(lo_sum), .carry_q(carry_q)
    );

    csacc_delay #(.WIDTH(SKEW_W), .DEPTH(1)) u_skew (
        .clk(clk), .rst(rst),
        .d({ctl_now, in_data[W-1:LO_W]}),
        .q({ctl_late, hi_opnd_late})
    );

    csacc_hi #(.HW(HI_W)) u_hi (
        .clk(clk), .rst(rst), .ctl_d(ctl_late), .opnd_d(hi_opnd_late),
        .carry_in(carry_q), .part_sum(hi_sum)
    );

    csacc_delay #(.WIDTH(LO_W), .DEPTH(1)) u_align (
        .clk(clk), .rst(rst), .d(lo_sum), .q(lo_sum_late)
    );

    csacc_delay #(.WIDTH(1), .DEPTH(2)) u_vld (
        .clk(clk), .rst(rst), .d(in_en), .q(out_valid)
    );

    assign out_sum = {hi_sum, lo_sum_late};

    // R2: valid tracks the enable two edges later
    a_r2_valid_tracks_en: assert property (@(posedge clk) disable iff (rst)
        in_en |=> ##1 out_valid);
    a_r2_idle_not_valid: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> ##1 !out_valid);
    // R4: a clear alone empties the sum
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (in_clr && !in_en) |=> ##1 (out_sum == '0));
    // R5: a clear with an add restarts at the operand
    a_r5_restart_value: assert property (@(posedge clk) disable iff (rst)
        (in_clr && in_en) |=> ##1 (out_sum == $past(in_data, 2)));
    // R3: an idle input leaves the aligned word unchanged
    a_r3_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!in_en && !in_clr) |=> ##1 $stable(out_sum));
endmodule

// File: tb/carry_split_acc_test.sv
`timescale 1ns/1ps
module carry_split_acc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_en = 1'b0, in_clr = 1'b0;
    logic [7:0]  d_s = '0;
    logic [40:0] d_w = '0;
    logic [7:0]  sum_s;
    logic [40:0] sum_w;
    logic        vld_s, vld_w;

    int n_cmp = 0, n_bad = 0;
    logic [7:0]  ref_s = '0, prev_s = '0;
    logic [40:0] ref_w = '0, prev_w = '0;
    logic        prev_v = 1'b0;
    string       prev_tag = "R8";

    always #2 clk = ~clk;

    carry_split_acc #(.W(8), .LO_W(3)) uut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_clr(in_clr), .in_data(d_s),
        .out_sum(sum_s), .out_valid(vld_s));

    carry_split_acc uut_wide (
        .clk(clk), .rst(rst), .in_en(in_en), .in_clr(in_clr), .in_data(d_w),
        .out_sum(sum_w), .out_valid(vld_w));

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [40:0] act, input logic [40:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic clr, input logic [40:0] dw,
                        input string tag);
        @(negedge clk);
        in_en = en; in_clr = clr; d_s = dw[7:0]; d_w = dw;
        @(posedge clk); #1;
        check(sum_s == prev_s, prev_tag, "narrow sum", 41'(sum_s), 41'(prev_s));
        check(sum_w == prev_w, prev_tag, "wide sum", sum_w, prev_w);
        check(vld_s == prev_v && vld_w == prev_v, "R2", "valid",
              41'({vld_s, vld_w}), 41'({prev_v, prev_v}));
        if (clr) begin
            ref_s = en ? dw[7:0] : '0;
            ref_w = en ? dw : '0;
        end else if (en) begin
            ref_s = ref_s + dw[7:0];
            ref_w = ref_w + dw;
        end
        prev_s = ref_s; prev_w = ref_w; prev_v = en; prev_tag = tag;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(sum_s == 0 && sum_w == 0, "R8", "sum in reset", sum_w, 0);
        check(!vld_s && !vld_w, "R8", "valid in reset", 41'(vld_w), 0);
        @(negedge clk); rst = 1'b0;

        // R6: carry across the split point
        step(1, 1, 41'h0_001F_FFFF, "R5");
        step(1, 0, 41'h1, "R6");
        step(1, 0, 41'h0_000F_FFFF, "R6");
        step(1, 0, 41'h0_0010_0001, "R6");
        // R7: wrap past the top bit
        step(1, 1, {41{1'b1}}, "R5");
        step(1, 0, {41{1'b1}}, "R7");
        step(1, 0, 41'h2, "R7");
        // R9: carry generated right before a clear must vanish
        step(1, 1, 41'h0_001F_FFFF, "R5");
        step(1, 0, 41'h0_001F_FFFF, "R6");
        step(1, 1, 41'h5, "R9");
        step(0, 0, 41'h1_2345_6789, "R3");
        step(1, 0, 41'h0_001F_FFFF, "R1");
        step(0, 1, 41'h7, "R9");
        step(0, 0, 41'hFF, "R3");
        step(0, 1, 41'h3, "R4");

        // Sweep every narrow operand, twice, with mixed controls
        for (int i = 0; i < 512; i++) begin
            logic en, clr;
            logic [40:0] dv;
            en  = (i % 5) != 0;
            clr = (i % 23) == 0;
            dv  = 41'(i) * 41'h0_0357_9BDF + 41'(i % 256);
            dv[7:0] = 8'(i);
            step(en, clr, dv, clr ? (en ? "R5" : "R4") : (en ? "R1" : "R3"));
        end
        for (int i = 0; i < 256; i++) step(1, 0, 41'h1F_FFFF_FFFF - 41'(i), "R7");
        step(0, 0, 41'h0, "R3");
        step(0, 0, 41'h0, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule